// File: doc/BRIEF.md
# SRAM DLL Initialization Sequencer

This block sits on the controller side of a synchronous SRAM that contains its own delay-locked loop. After reset it keeps the memory's DLL switched off until the board reports good power and a settled input clock. It then starts the DLL and waits a fixed number of reference-clock cycles for it to lock. Only then does it raise a ready flag that lets the command path issue reads and writes. After that it watches for events that invalidate the lock, such as a change of operating frequency or a loss of clock stability. On any of these it withdraws ready and runs the relock procedure again.

Boards wire the memory's DLL-disable pin in one of two ways. In pin-controlled mode the sequencer drives the pin low to reset the DLL. In tied-high mode the pin is strapped on, so the sequencer resets the DLL by gating the memory clock off for a minimum stop interval. A configured frequency below the DLL's operating floor sends the sequencer into a sticky error state, and ready stays withheld there. All inputs are synchronous to `clk`. `rst_n` is asserted asynchronously and released through a two-stage synchronizer.

Top module: `sram_dll_bringup`

## Requirements
- R1: During reset and in the cycles after it while `pwr_good` is low, `dll_en_o`=0 (DLL off), `ready_o`=0, `err_o`=0 and `mclk_en_o`=1 (memory clock passed through).
- R2: `dll_en_o` only rises on the clock edge after a cycle in which both `pwr_good` and `clk_stable` were sampled 1. While `clk_stable` is 0 the lock count is never started.
- R3: `ready_o` rises exactly `LOCK_CYCLES` cycles (default 2048) after `dll_en_o` rises. Every entry into the lock wait reloads the full count.
- R4: With `pin_mode`=1 (pin-controlled), `mclk_en_o` never goes low. `dll_en_o` rises one cycle after `clk_stable` is sampled high in the DLL-off state.
- R5: With `pin_mode`=0 (tied-high), the DLL reset is `mclk_en_o`=0 for exactly `STOP_CYCLES` cycles. `STOP_CYCLES` = ceil(`STOP_NS` / clock period) + 1, which is 5 at the default 30 ns and 8 ns. The lock wait starts in the cycle the clock is re-enabled.
- R6: A one-cycle `freq_chg` pulse during the stop, lock-wait or ready phases clears `ready_o` on the next edge. The DLL is then reset again: the pin goes low for one cycle in pin mode, or the clock stops again in tied mode. A full lock count follows.
- R7: If `clk_stable` is sampled 0 during the stop, lock-wait or ready phases, `ready_o` clears on the next edge. The sequencer then holds the DLL off with the clock running until `clk_stable` returns, and restarts from there.
- R8: If `freq_mhz` (unsigned, MHz) is below `MIN_FREQ_MHZ` (default 120) when the DLL would be started or restarted, `err_o` rises instead and `ready_o` stays 0.
- R9: The error state leaves only on reset or on a `freq_chg` pulse with `freq_mhz` >= `MIN_FREQ_MHZ`, and in the second case it goes to the DLL-off state. A low `pwr_good`, or a request that still carries a too-low frequency, keeps `err_o`=1.
- R10: Outside the error state, `pwr_good` sampled 0 returns the sequencer to the power-wait state on the next edge: DLL off, ready clear, clock passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_good | input | 1 | Memory supplies reported stable |
| clk_stable | input | 1 | Memory input clock reported stable |
| freq_chg | input | 1 | One-cycle request: operating frequency has changed |
| pin_mode | input | 1 | 1 = DLL-disable pin driven by this block, 0 = pin tied high |
| freq_mhz | input | FREQ_W | Configured operating frequency in MHz |
| dll_en_o | output | 1 | Drive for the memory DLL-disable pin (1 = DLL on) |
| mclk_en_o | output | 1 | Memory clock gate enable (0 = clock stopped) |
| ready_o | output | 1 | DLL locked, commands may be issued |
| err_o | output | 1 | Configured frequency below the DLL floor |

## Verification
Some properties are checked every cycle. The DLL is never started without stable power and clock in the preceding cycle. Ready never rises before the enable has been up for the full lock count. The clock is never re-enabled into a lock wait before the full stop interval. Ready drops one edge after a frequency request or a clock loss. The error flag holds until a valid request. The exact interval lengths in both modes, the one-cycle pin pulse on a relock, the holding pattern while the clock is unstable, and the behaviour at power-up with a bad frequency need the bench's scenarios. There a behavioural reference model is compared on every clock.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [2:0] {
    ST_POWER_WAIT = 3'd0,
    ST_DLL_OFF    = 3'd1,
    ST_CLK_STOP   = 3'd2,
    ST_LOCK_WAIT  = 3'd3,
    ST_READY      = 3'd4,
    ST_ERROR      = 3'd5
  } bring_st_e;

  function automatic int unsigned stop_cycles_for(input int unsigned stop_ns,
                                                  input int unsigned period_ps);
    return (stop_ns * 1000 + period_ps - 1) / period_ps + 1;
  endfunction

endpackage

// File: rtl/bringup_rst_sync.sv
module bringup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import bringup_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int LOCK_CYCLES = 2048,
  parameter int STOP_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             clk_stable,
  input  logic             freq_chg,
  input  logic             pin_mode,
  input  logic             freq_low,
  input  logic             expired,
  output bring_st_e        state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_run
);

  localparam logic [CNT_W-1:0] LOCK_M1 = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] STOP_M1 = CNT_W'(STOP_CYCLES - 1);

  bring_st_e st_q;
  bring_st_e st_d;
  bring_st_e relock_st;

  // Where a DLL reset goes once the current lock is invalidated
  always_comb begin
    if (!clk_stable) begin
      relock_st = ST_DLL_OFF;
    end else if (freq_low) begin
      relock_st = ST_ERROR;
    end else if (pin_mode) begin
      relock_st = ST_DLL_OFF;
    end else begin
      relock_st = ST_CLK_STOP;
    end
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_run  = 1'b0;
    if (st_q == ST_ERROR) begin
      if (freq_chg && !freq_low) begin
        st_d = ST_DLL_OFF;
      end
    end else if (!pwr_good) begin
      st_d = ST_POWER_WAIT;
    end else begin
      unique case (st_q)
        ST_POWER_WAIT: st_d = ST_DLL_OFF;
        ST_DLL_OFF: begin
          if (clk_stable) begin
            if (freq_low) begin
              st_d = ST_ERROR;
            end else if (pin_mode) begin
              st_d     = ST_LOCK_WAIT;
              tmr_load = 1'b1;
              tmr_val  = LOCK_M1;
            end else begin
              st_d     = ST_CLK_STOP;
              tmr_load = 1'b1;
              tmr_val  = STOP_M1;
            end
          end
        end
        ST_CLK_STOP, ST_LOCK_WAIT, ST_READY: begin
          if (!clk_stable || freq_chg) begin
            st_d = relock_st;
            if (relock_st == ST_CLK_STOP) begin
              tmr_load = 1'b1;
              tmr_val  = STOP_M1;
            end
          end else if (st_q == ST_CLK_STOP) begin
            if (expired) begin
              st_d     = ST_LOCK_WAIT;
              tmr_load = 1'b1;
              tmr_val  = LOCK_M1;
            end else begin
              tmr_run = 1'b1;
            end
          end else if (st_q == ST_LOCK_WAIT) begin
            if (expired) begin
              st_d = ST_READY;
            end else begin
              tmr_run = 1'b1;
            end
          end
        end
        default: st_d = ST_POWER_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_POWER_WAIT;
    end else begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/sram_dll_bringup.sv
module sram_dll_bringup
  import bringup_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int STOP_NS       = 30,
  parameter int LOCK_CYCLES   = 2048,
  parameter int FREQ_W        = 12,
  parameter int MIN_FREQ_MHZ  = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              clk_stable,
  input  logic              freq_chg,
  input  logic              pin_mode,
  input  logic [FREQ_W-1:0] freq_mhz,
  output logic              dll_en_o,
  output logic              mclk_en_o,
  output logic              ready_o,
  output logic              err_o
);

  localparam int STOP_CYCLES = stop_cycles_for(STOP_NS, CLK_PERIOD_PS);
  localparam int MAX_CNT     = (LOCK_CYCLES > STOP_CYCLES) ? LOCK_CYCLES : STOP_CYCLES;
  localparam int CNT_W       = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  logic             rst_n_int;
  logic             freq_low;
  logic             expired;
  logic             tmr_load;
  logic             tmr_run;
  logic [CNT_W-1:0] tmr_val;
  bring_st_e        state;

  bringup_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign freq_low = (freq_mhz < FREQ_W'(MIN_FREQ_MHZ));

  bringup_fsm #(
    .CNT_W       (CNT_W),
    .LOCK_CYCLES (LOCK_CYCLES),
    .STOP_CYCLES (STOP_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .pwr_good   (pwr_good),
    .clk_stable (clk_stable),
    .freq_chg   (freq_chg),
    .pin_mode   (pin_mode),
    .freq_low   (freq_low),
    .expired    (expired),
    .state      (state),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_run    (tmr_run)
  );

  bringup_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (expired)
  );

  assign dll_en_o  = (state == ST_LOCK_WAIT) || (state == ST_READY);
  assign mclk_en_o = (state != ST_CLK_STOP);
  assign ready_o   = (state == ST_READY);
  assign err_o     = (state == ST_ERROR);

endmodule

// File: rtl/bringup_checker.sv
module bringup_checker #(
  parameter int LOCK_CYCLES  = 2048,
  parameter int STOP_CYCLES  = 5,
  parameter int FREQ_W       = 12,
  parameter int MIN_FREQ_MHZ = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              clk_stable,
  input logic              freq_chg,
  input logic [FREQ_W-1:0] freq_mhz,
  input logic              dll_en_o,
  input logic              mclk_en_o,
  input logic              ready_o,
  input logic              err_o
);

  logic [31:0] en_run_q;
  logic [31:0] stop_run_q;
  logic        freq_ok;

  assign freq_ok = (freq_mhz >= FREQ_W'(MIN_FREQ_MHZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_run_q   <= '0;
      stop_run_q <= '0;
    end else begin
      if (!dll_en_o) begin
        en_run_q <= '0;
      end else if (en_run_q != 32'hFFFF_FFFF) begin
        en_run_q <= en_run_q + 1'b1;
      end
      if (mclk_en_o) begin
        stop_run_q <= '0;
      end else if (stop_run_q != 32'hFFFF_FFFF) begin
        stop_run_q <= stop_run_q + 1'b1;
      end
    end
  end

  a_r1_off_without_power: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !err_o) |=> (!dll_en_o && !ready_o));

  a_r2_start_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> ($past(clk_stable) && $past(pwr_good)));

  a_r3_full_lock_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (en_run_q >= LOCK_CYCLES));

  a_r5_full_stop_interval: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mclk_en_o) && dll_en_o) |-> (stop_run_q >= STOP_CYCLES));

  a_r6_ready_drops_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && freq_chg) |=> !ready_o);

  a_r7_ready_drops_on_unstable: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !clk_stable) |=> !ready_o);

  a_r8_low_freq_error: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && pwr_good && clk_stable && freq_chg && !freq_ok) |=> (err_o && !ready_o));

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(freq_chg && freq_ok)) |=> err_o);

  a_r10_power_loss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !err_o) |=> mclk_en_o);

endmodule

bind sram_dll_bringup bringup_checker #(
  .LOCK_CYCLES  (LOCK_CYCLES),
  .STOP_CYCLES  (STOP_CYCLES),
  .FREQ_W       (FREQ_W),
  .MIN_FREQ_MHZ (MIN_FREQ_MHZ)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .clk_stable (clk_stable),
  .freq_chg   (freq_chg),
  .freq_mhz   (freq_mhz),
  .dll_en_o   (dll_en_o),
  .mclk_en_o  (mclk_en_o),
  .ready_o    (ready_o),
  .err_o      (err_o)
);

// File: tb/sram_dll_bringup_bench.sv
`timescale 1ns/1ps
module sram_dll_bringup_bench;

  localparam int LOCK = 2048;
  localparam int STOP = 5;
  localparam int MINF = 120;

  logic        clk;
  logic        rst_n;
  logic        pwr_good;
  logic        clk_stable;
  logic        freq_chg;
  logic        pin_mode;
  logic [11:0] freq;
  logic        dll_en;
  logic        mclk_en;
  logic        ready;
  logic        err;

  int checks;
  int failures;
  bit done;

  sram_dll_bringup u_sram_dll_bringup (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .clk_stable (clk_stable),
    .freq_chg   (freq_chg),
    .pin_mode   (pin_mode),
    .freq_mhz   (freq),
    .dll_en_o   (dll_en),
    .mclk_en_o  (mclk_en),
    .ready_o    (ready),
    .err_o      (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: phase number plus remaining-cycle count
  localparam int M_PW = 0, M_OFF = 1, M_STOP = 2, M_LOCK = 3, M_RDY = 4, M_ERR = 5;
  int ph;
  int rem;

  task automatic model_start_dll(input bit via_pin);
    if (freq < MINF) begin
      ph = M_ERR;
    end else if (via_pin) begin
      ph = M_LOCK; rem = LOCK;
    end else begin
      ph = M_STOP; rem = STOP;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = M_PW; rem = 0;
    end else if (ph == M_ERR) begin
      if (freq_chg && freq >= MINF) ph = M_OFF;
    end else if (!pwr_good) begin
      ph = M_PW;
    end else if (ph == M_PW) begin
      ph = M_OFF;
    end else if (ph == M_OFF) begin
      if (clk_stable) model_start_dll(pin_mode);
    end else if (!clk_stable) begin
      ph = M_OFF;
    end else if (freq_chg) begin
      if (pin_mode && freq >= MINF) ph = M_OFF;
      else model_start_dll(1'b0);
    end else if (ph == M_STOP) begin
      rem--;
      if (rem == 0) begin ph = M_LOCK; rem = LOCK; end
    end else if (ph == M_LOCK) begin
      rem--;
      if (rem == 0) ph = M_RDY;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", dll_en,  (ph == M_LOCK || ph == M_RDY) ? 1 : 0, "model dll_en");
      chk("R5", mclk_en, (ph != M_STOP) ? 1 : 0, "model mclk_en");
      chk("R3", ready,   (ph == M_RDY) ? 1 : 0, "model ready");
      chk("R8", err,     (ph == M_ERR) ? 1 : 0, "model err");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_chg(input int f);
    freq = 12'(f); freq_chg = 1'b1;
    @(negedge clk);
    freq_chg = 1'b0;
  endtask

  // Called at a negedge where dll_en has just risen; counts negedges to ready
  task automatic lock_len(output int m, output bit stopped);
    m = 0; stopped = 0;
    while (!ready && m < 5000) begin
      @(negedge clk);
      m++;
      if (!mclk_en) stopped = 1;
    end
  endtask

  task automatic stop_len(output int s);
    int w;
    w = 0; s = 0;
    while (mclk_en && w < 20) begin @(negedge clk); w++; end
    while (!mclk_en && s < 100) begin s++; @(negedge clk); end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int m;
    int s;
    int n;
    bit stopped;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; pwr_good = 1'b0; clk_stable = 1'b0; freq_chg = 1'b0;
    pin_mode = 1'b1; freq = 12'd200;
    cyc(4);
    // R1 reset state
    chk("R1", dll_en, 0, "reset dll_en");
    chk("R1", ready, 0, "reset ready");
    chk("R1", err, 0, "reset err");
    chk("R1", mclk_en, 1, "reset mclk_en");
    rst_n = 1'b1;
    cyc(6);
    chk("R1", dll_en, 0, "no power dll_en");
    chk("R1", ready, 0, "no power ready");

    // R2: power good but clock unstable keeps DLL off
    pwr_good = 1'b1;
    cyc(20);
    chk("R2", dll_en, 0, "unstable clock dll_en");

    // R4 pin mode bring-up
    clk_stable = 1'b1;
    n = 0;
    while (!dll_en && n < 10) begin @(negedge clk); n++; end
    chk("R4", n, 1, "cycles stable->dll_en");
    lock_len(m, stopped);
    chk("R3", m, LOCK, "lock cycles pin mode");
    chk("R4", stopped, 0, "clock stop in pin mode");

    // R6 frequency change in pin mode
    cyc(10);
    pulse_chg(250);
    chk("R6", ready, 0, "ready after freq change");
    chk("R6", dll_en, 0, "dll pin pulse low");
    @(negedge clk);
    chk("R6", dll_en, 1, "dll re-enabled");
    lock_len(m, stopped);
    chk("R6", m, LOCK, "relock length pin mode");

    // R7 clock loss during ready, then during lock wait
    cyc(5);
    clk_stable = 1'b0;
    @(negedge clk);
    chk("R7", ready, 0, "ready after clock loss");
    cyc(30);
    chk("R7", dll_en, 0, "dll held off while unstable");
    chk("R7", mclk_en, 1, "clock runs while unstable");
    clk_stable = 1'b1;
    @(negedge clk);
    chk("R7", dll_en, 1, "restart when stable");
    cyc(100);
    clk_stable = 1'b0;
    @(negedge clk);
    chk("R7", dll_en, 0, "lock wait aborted");
    cyc(3);
    clk_stable = 1'b1;
    @(negedge clk);
    lock_len(m, stopped);
    chk("R7", m, LOCK, "full count after abort");

    // R8/R9 low frequency request, sticky error
    cyc(5);
    pulse_chg(100);
    chk("R8", err, 1, "err on low frequency");
    chk("R8", ready, 0, "ready withheld");
    cyc(3);
    pulse_chg(90);
    chk("R9", err, 1, "err kept on low request");
    pwr_good = 1'b0;
    cyc(5);
    chk("R9", err, 1, "err kept on power loss");
    pwr_good = 1'b1;
    cyc(2);
    pulse_chg(150);
    chk("R9", err, 0, "err left on valid request");
    chk("R9", dll_en, 0, "error exit into dll off");
    @(negedge clk);
    chk("R9", dll_en, 1, "dll started after error");
    lock_len(m, stopped);
    chk("R9", m, LOCK, "lock after error");

    // R10 power loss while ready
    cyc(4);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R10", ready, 0, "ready on power loss");
    chk("R10", dll_en, 0, "dll on power loss");
    chk("R10", mclk_en, 1, "clock on power loss");
    pwr_good = 1'b1;
    cyc(4);

    // R5 tied-high mode bring-up
    rst_n = 1'b0; pwr_good = 1'b0; clk_stable = 1'b0; pin_mode = 1'b0; freq = 12'd200;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    pwr_good = 1'b1; clk_stable = 1'b1;
    stop_len(s);
    chk("R5", s, STOP, "stop interval tied mode");
    chk("R5", dll_en, 1, "lock wait after stop");
    lock_len(m, stopped);
    chk("R3", m, LOCK, "lock cycles tied mode");

    // R6 frequency change in tied mode: clock stops again
    cyc(7);
    pulse_chg(300);
    chk("R6", ready, 0, "ready after change tied");
    chk("R6", mclk_en, 0, "clock stopped tied");
    stop_len(s);
    chk("R6", s, STOP, "stop interval on relock");
    lock_len(m, stopped);
    chk("R6", m, LOCK, "relock length tied");

    // R8 low frequency at power-up
    rst_n = 1'b0; pwr_good = 1'b0; clk_stable = 1'b0; pin_mode = 1'b1; freq = 12'd100;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    pwr_good = 1'b1; clk_stable = 1'b1;
    cyc(2);
    chk("R8", err, 1, "err at power-up");
    cyc(3000);
    chk("R8", ready, 0, "ready withheld at power-up");
    chk("R8", dll_en, 0, "dll off at power-up error");

    summary();
  end

endmodule